// File: doc/BRIEF.md
# Paired-Instruction Fusion Detector

This block sits in the decode stage of a 64-bit RISC-V core and looks at two adjacent 32-bit instruction words. It decides whether the pair can be handled as one fused macro-operation and, if so, which of twelve pair kinds it is. The kinds cover constant building with an upper immediate, PC-relative address formation, zero extension and bitfield extraction done with a shift pair, and address calculation followed by a load.

Each kind has its own bit in an enable mask, so a core can turn on only the pairs its back end can execute. When more than one enabled kind fits the same pair, a fixed priority picks the most specific one. The result is registered. The block presents it one clock after the words arrive as three outputs: a fuse flag, a 4-bit kind code and the shared destination register.

Top module: `fuse_pair_detect`

## Requirements
- R1: Outputs are registered. A pair presented before a rising edge is reported after that edge. A synchronous reset drives fuse_o to 0, kind_o to 0 and rd_o to 0. Whenever fuse_o is 0, kind_o and rd_o are both 0.
- R2: A pair fuses only when all of these hold: both valid inputs are 1, the first word's rd (bits 11:7) is not x0, the second word's rs1 (bits 19:15) equals that rd, and the second word's rd equals that rd. On a fusion, rd_o carries that register.
- R3: LUI (opcode 0110111) followed by ADDI (opcode 0010011, funct3 000) or by ADDIW (opcode 0011011, funct3 000) gives code 5. AUIPC (opcode 0010111) followed by ADDI gives code 6. AUIPC followed by ADDIW does not fuse.
- R4: SLLI by 48 followed by SRLI by 48 gives code 1. SLLI by 32 followed by SRLI by 32 gives code 2. SLLI is opcode 0010011 with funct3 001; SRLI is the same opcode with funct3 101. The shift amount is bits 25:20.
- R5: SLLI by 32 followed by SRLI by any amount from 0 to 31 gives code 3.
- R6: Any other SLLI followed by any SRLI gives code 4. A shift counts as SLLI or SRLI only when bits 31:26 are zero, so an SRAI second word does not fuse.
- R7: ADD (opcode 0110011, funct7 0, funct3 000) followed by LD whose 12-bit offset is zero gives code 7. ADD, or ADD.UW (opcode 0111011, funct7 0000100, funct3 000), followed by any load gives code 8.
- R8: Each of the following, followed by any load, gives its own code. SH1ADD, SH2ADD and SH3ADD and their .UW forms give code 9. These have funct7 0010000 and funct3 010, 100 or 110, on opcode 0110011 or 0111011. ADDI gives code 10, AUIPC gives code 11 and LUI gives code 12.
- R9: Enable bit k-1 of kind_en_i gates code k. A clear bit stops that kind from being reported, and the pair then falls to the next enabled kind that matches. With the mask all zero, nothing fuses.
- R10: When several enabled kinds match, the lowest code wins.
- R11: A load is opcode 0000011 with funct3 000 to 110 (LB, LH, LW, LD, LBU, LHU, LWU); LD is funct3 011. Funct3 111 on that opcode is not a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_valid_i | input | 1 | First instruction word is valid |
| a_insn_i | input | 32 | First (older) instruction word |
| b_valid_i | input | 1 | Second instruction word is valid |
| b_insn_i | input | 32 | Second (younger) instruction word |
| kind_en_i | input | 12 | Per-kind enable; bit k-1 enables code k |
| fuse_o | output | 1 | Registered: the pair fuses |
| kind_o | output | 4 | Registered fusion kind code, 0 when none |
| rd_o | output | 5 | Registered shared destination register, 0 when none |

## Verification
All three results are due exactly one rising edge after the pair is presented, and nothing else has a longer delay. The driver applies each pair on a falling edge and puts the expected code and register into a queue. The monitor takes one entry per rising edge and compares it a short time after that edge, so each comparison lines up with the single register stage. Reset is checked directly while a fusible pair is held on the inputs.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

   localparam int N_KINDS = 12;
   localparam int KIND_W  = $clog2(N_KINDS + 1);

   // kind codes; bit (code-1) of the enable / hit vectors
   localparam logic [KIND_W-1:0] K_NONE       = 4'd0;
   localparam logic [KIND_W-1:0] K_ZEXT_HALF  = 4'd1;
   localparam logic [KIND_W-1:0] K_ZEXT_WORD  = 4'd2;
   localparam logic [KIND_W-1:0] K_SHIFT_ZEXT = 4'd3;
   localparam logic [KIND_W-1:0] K_BITFIELD   = 4'd4;
   localparam logic [KIND_W-1:0] K_UPPER_ADDI = 4'd5;
   localparam logic [KIND_W-1:0] K_PCREL_ADDI = 4'd6;
   localparam logic [KIND_W-1:0] K_ADD_LD0    = 4'd7;
   localparam logic [KIND_W-1:0] K_ADD_LOAD   = 4'd8;
   localparam logic [KIND_W-1:0] K_SCALE_LOAD = 4'd9;
   localparam logic [KIND_W-1:0] K_ADDI_LOAD  = 4'd10;
   localparam logic [KIND_W-1:0] K_PCREL_LOAD = 4'd11;
   localparam logic [KIND_W-1:0] K_UPPER_LOAD = 4'd12;

   // major opcodes
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_IMM    = 7'b0010011;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_IMM32  = 7'b0011011;
   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_UPPER  = 7'b0110111;
   localparam logic [6:0] OPC_REG32  = 7'b0111011;

   localparam logic [6:0] F7_BASE    = 7'b0000000;
   localparam logic [6:0] F7_UWADD   = 7'b0000100;
   localparam logic [6:0] F7_SCALE   = 7'b0010000;

   // per-word class flags produced by the decoder
   typedef struct packed {
      logic       up_imm;    // LUI
      logic       pc_imm;    // AUIPC
      logic       addi;
      logic       addiw;
      logic       add;
      logic       add_uw;
      logic       scale_add; // SHxADD / SHxADD.UW
      logic       shl;       // SLLI
      logic       shr;       // SRLI
      logic       load;
      logic       ld;
      logic       off_zero;
      logic [5:0] shamt;
      logic [4:0] rd;
      logic [4:0] rs1;
   } insn_cls_t;

endpackage

// File: rtl/fuse_insn_decode.sv
module fuse_insn_decode
   import fuse_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic [ILEN-1:0] insn_i,
   output insn_cls_t       cls_o
);

   if (ILEN != 32) begin : g_bad_ilen
      $error("fuse_insn_decode: ILEN must be 32");
   end

   logic [6:0]  opc;
   logic [2:0]  f3;
   logic [6:0]  f7;
   logic [5:0]  f6;
   logic [11:0] imm12;

   assign opc   = insn_i[6:0];
   assign f3    = insn_i[14:12];
   assign f7    = insn_i[31:25];
   assign f6    = insn_i[31:26];
   assign imm12 = insn_i[31:20];

   always_comb begin
      cls_o           = '0;
      cls_o.rd        = insn_i[11:7];
      cls_o.rs1       = insn_i[19:15];
      cls_o.shamt     = insn_i[25:20];
      cls_o.off_zero  = (imm12 == 12'd0);
      cls_o.up_imm    = (opc == OPC_UPPER);
      cls_o.pc_imm    = (opc == OPC_AUIPC);
      cls_o.addi      = (opc == OPC_IMM)   && (f3 == 3'b000);
      cls_o.addiw     = (opc == OPC_IMM32) && (f3 == 3'b000);
      cls_o.shl       = (opc == OPC_IMM)   && (f3 == 3'b001) && (f6 == 6'd0);
      cls_o.shr       = (opc == OPC_IMM)   && (f3 == 3'b101) && (f6 == 6'd0);
      cls_o.add       = (opc == OPC_REG)   && (f3 == 3'b000) && (f7 == F7_BASE);
      cls_o.add_uw    = (opc == OPC_REG32) && (f3 == 3'b000) && (f7 == F7_UWADD);
      cls_o.scale_add = ((opc == OPC_REG) || (opc == OPC_REG32)) &&
                        (f7 == F7_SCALE) && (f3[0] == 1'b0) && (f3 != 3'b000);
      cls_o.load      = (opc == OPC_LOAD) && (f3 != 3'b111);
      cls_o.ld        = (opc == OPC_LOAD) && (f3 == 3'b011);
   end

   always_comb begin
      if (cls_o.ld) AST_LD_IS_LOAD: assert (cls_o.load);  // R11
      if (cls_o.shl || cls_o.shr) AST_SHIFT_HIGH_ZERO: assert (insn_i[31:26] == 6'd0);  // R6
   end

endmodule

// File: rtl/fuse_kind_match.sv
module fuse_kind_match
   import fuse_pkg::*;
#(
   parameter int NK = N_KINDS
) (
   input  insn_cls_t      first_i,
   input  insn_cls_t      second_i,
   input  logic           pair_ok_i,
   input  logic [NK-1:0]  en_i,
   output logic [NK-1:0]  hit_o
);

   localparam int HALF_SH = 48;
   localparam int WORD_SH = 32;

   if (NK != N_KINDS) begin : g_bad_nk
      $error("fuse_kind_match: NK must equal the kind count");
   end

   logic [NK-1:0] raw;
   logic          shl_half, shl_word, shr_half, shr_word, shr_low;
   logic          unused_fields;

   assign unused_fields = ^{first_i, second_i};

   assign shl_half = first_i.shl  && (first_i.shamt  == 6'(HALF_SH));
   assign shl_word = first_i.shl  && (first_i.shamt  == 6'(WORD_SH));
   assign shr_half = second_i.shr && (second_i.shamt == 6'(HALF_SH));
   assign shr_word = second_i.shr && (second_i.shamt == 6'(WORD_SH));
   assign shr_low  = second_i.shr && (second_i.shamt < 6'(WORD_SH));

   always_comb begin
      raw = '0;
      raw[K_ZEXT_HALF  - 1] = shl_half && shr_half;
      raw[K_ZEXT_WORD  - 1] = shl_word && shr_word;
      raw[K_SHIFT_ZEXT - 1] = shl_word && shr_low;
      raw[K_BITFIELD   - 1] = first_i.shl && second_i.shr;
      raw[K_UPPER_ADDI - 1] = first_i.up_imm && (second_i.addi || second_i.addiw);
      raw[K_PCREL_ADDI - 1] = first_i.pc_imm && second_i.addi;
      raw[K_ADD_LD0    - 1] = first_i.add && second_i.ld && second_i.off_zero;
      raw[K_ADD_LOAD   - 1] = (first_i.add || first_i.add_uw) && second_i.load;
      raw[K_SCALE_LOAD - 1] = first_i.scale_add && second_i.load;
      raw[K_ADDI_LOAD  - 1] = first_i.addi && second_i.load;
      raw[K_PCREL_LOAD - 1] = first_i.pc_imm && second_i.load;
      raw[K_UPPER_LOAD - 1] = first_i.up_imm && second_i.load;
   end

   assign hit_o = raw & en_i & {NK{pair_ok_i}};

   always_comb begin
      if (raw[K_ADD_LD0 - 1]) AST_LD0_ALSO_ADDLOAD: assert (raw[K_ADD_LOAD - 1]);  // R7
      if (raw[K_ZEXT_HALF - 1] || raw[K_ZEXT_WORD - 1])
         AST_ZEXT_ALSO_BITFIELD: assert (raw[K_BITFIELD - 1]);  // R4
      AST_ZEXT_EXCLUSIVE: assert (!(raw[K_ZEXT_HALF - 1] && raw[K_ZEXT_WORD - 1]));  // R4
   end

endmodule

// File: rtl/fuse_prio_pick.sv
module fuse_prio_pick #(
   parameter int N  = 12,
   localparam int KW = $clog2(N + 1)
) (
   input  logic [N-1:0]  req_i,
   output logic [N-1:0]  gnt_o,
   output logic [KW-1:0] code_o,
   output logic          any_o
);

   if (N < 2) begin : g_bad_n
      $error("fuse_prio_pick: N must be at least 2");
   end

   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt_o[i]       = req_i[i] && !blocked[i];
      assign blocked[i + 1] = blocked[i] || req_i[i];
   end

   assign any_o = blocked[N];

   always_comb begin
      code_o = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt_o[i]) code_o = code_o | KW'(i + 1);
      end
   end

   always_comb begin
      AST_GRANT_ONEHOT: assert ($onehot0(gnt_o));  // R10
      if (any_o) AST_ANY_HAS_GRANT: assert (gnt_o != '0);  // R10
   end

endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
   import fuse_pkg::*;
#(
   parameter int ILEN  = 32,
   parameter int REG_W = 5,
   parameter int NK    = N_KINDS,
   localparam int KW   = $clog2(NK + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             a_valid_i,
   input  logic [ILEN-1:0]  a_insn_i,
   input  logic             b_valid_i,
   input  logic [ILEN-1:0]  b_insn_i,
   input  logic [NK-1:0]    kind_en_i,
   output logic             fuse_o,
   output logic [KW-1:0]    kind_o,
   output logic [REG_W-1:0] rd_o
);

   if (ILEN != 32) begin : g_bad_ilen
      $error("fuse_pair_detect: ILEN must be 32");
   end
   if (REG_W != 5) begin : g_bad_regw
      $error("fuse_pair_detect: REG_W must be 5");
   end
   if (NK != N_KINDS) begin : g_bad_nk
      $error("fuse_pair_detect: NK must equal the kind count");
   end

   localparam int N_SLOT = 2;

   logic [ILEN-1:0] slot_insn [N_SLOT];
   insn_cls_t       slot_cls  [N_SLOT];

   assign slot_insn[0] = a_insn_i;
   assign slot_insn[1] = b_insn_i;

   for (genvar s = 0; s < N_SLOT; s++) begin : g_dec
      fuse_insn_decode #(.ILEN(ILEN)) u_dec (
         .insn_i (slot_insn[s]),
         .cls_o  (slot_cls[s])
      );
   end

   logic pair_ok;
   assign pair_ok = a_valid_i && b_valid_i &&
                    (slot_cls[0].rd != '0) &&
                    (slot_cls[1].rs1 == slot_cls[0].rd) &&
                    (slot_cls[1].rd  == slot_cls[0].rd);

   logic [NK-1:0] hits, grant;
   logic [KW-1:0] code;
   logic          any_hit;

   fuse_kind_match #(.NK(NK)) u_match (
      .first_i   (slot_cls[0]),
      .second_i  (slot_cls[1]),
      .pair_ok_i (pair_ok),
      .en_i      (kind_en_i),
      .hit_o     (hits)
   );

   fuse_prio_pick #(.N(NK)) u_pick (
      .req_i  (hits),
      .gnt_o  (grant),
      .code_o (code),
      .any_o  (any_hit)
   );

   logic unused_grant;
   assign unused_grant = ^grant;

   always_ff @(posedge clk) begin
      if (rst) begin
         fuse_o <= 1'b0;
         kind_o <= '0;
         rd_o   <= '0;
      end else begin
         fuse_o <= any_hit;
         kind_o <= any_hit ? code : '0;
         rd_o   <= any_hit ? REG_W'(slot_cls[0].rd) : '0;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!fuse_o && kind_o == '0 && rd_o == '0));  // R1
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !fuse_o |-> (kind_o == '0 && rd_o == '0));  // R1
   AST_NEED_BOTH_VALID: assert property (@(posedge clk) disable iff (rst)
      !(a_valid_i && b_valid_i) |=> !fuse_o);  // R2
   AST_RD_NONZERO: assert property (@(posedge clk) disable iff (rst)
      fuse_o |-> rd_o != '0);  // R2
   AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
      (kind_en_i == '0) |=> !fuse_o);  // R9
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
      fuse_o |-> (kind_o != '0 && kind_o <= KW'(NK)));  // R10

endmodule

// File: tb/fuse_pair_detect_test.sv
module fuse_pair_detect_test;

   localparam int PERIOD = 20;  // 50 MHz

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        a_valid_i = 1'b0, b_valid_i = 1'b0;
   logic [31:0] a_insn_i = '0, b_insn_i = '0;
   logic [11:0] kind_en_i = '1;
   logic        fuse_o;
   logic [3:0]  kind_o;
   logic [4:0]  rd_o;

   always #(PERIOD / 2) clk = ~clk;

   fuse_pair_detect uut (
      .clk(clk), .rst(rst),
      .a_valid_i(a_valid_i), .a_insn_i(a_insn_i),
      .b_valid_i(b_valid_i), .b_insn_i(b_insn_i),
      .kind_en_i(kind_en_i),
      .fuse_o(fuse_o), .kind_o(kind_o), .rd_o(rd_o)
   );

   typedef struct {
      logic [3:0] kind;
      logic [4:0] rd;
      string      tag;
   } exp_t;

   exp_t expq[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 0;

   localparam logic [6:0] LOAD = 7'b0000011, IMM = 7'b0010011, AUIPC = 7'b0010111,
                          IMM32 = 7'b0011011, REG = 7'b0110011, UPPER = 7'b0110111,
                          REG32 = 7'b0111011;

   function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
      return {imm, rs1, f3, rd, op};
   endfunction
   function automatic logic [31:0] enc_sh(logic [5:0] f6, logic [5:0] sh, logic [4:0] rs1,
                                          logic [2:0] f3, logic [4:0] rd);
      return {f6, sh, rs1, f3, rd, IMM};
   endfunction
   function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
      return {f7, rs2, rs1, f3, rd, op};
   endfunction
   function automatic logic [31:0] enc_u(logic [19:0] imm, logic [4:0] rd, logic [6:0] op);
      return {imm, rd, op};
   endfunction

   task automatic check(string tag, logic [3:0] kind, logic [4:0] rd,
                        logic [3:0] ek, logic [4:0] er);
      logic ef;
      ef = (ek != 4'd0);
      n_checks++;
      if (fuse_o !== ef || kind_o !== ek || rd_o !== er) begin
         n_errors++;
         $display("FAIL %s: got fuse=%0b kind=%0d rd=%0d, expected fuse=%0b kind=%0d rd=%0d",
                  tag, fuse_o, kind, rd, ef, ek, er);
      end
   endtask

   // driver: present a pair on a falling edge, queue the expected result
   task automatic send(string tag, logic [31:0] a, logic [31:0] b, logic va, logic vb,
                       logic [11:0] en, logic [3:0] ek, logic [4:0] er);
      exp_t e;
      @(negedge clk);
      a_insn_i = a; b_insn_i = b; a_valid_i = va; b_valid_i = vb; kind_en_i = en;
      e.kind = ek; e.rd = (ek != 4'd0) ? er : 5'd0; e.tag = tag;
      expq.push_back(e);
   endtask

   // monitor: results are due one rising edge after the pair was presented
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            check(e.tag, kind_o, rd_o, e.kind, e.rd);
         end
      end
   end

   initial begin
      #(PERIOD * 5000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   localparam logic [11:0] ALL = 12'hFFF;

   initial begin
      // R1: reset clears even with a fusible pair on the inputs
      a_insn_i = enc_u(20'h12345, 5'd5, UPPER);
      b_insn_i = enc_i(12'h678, 5'd5, 3'b000, 5'd5, IMM);
      a_valid_i = 1; b_valid_i = 1;
      repeat (3) @(posedge clk);
      #2 check("R1 reset", kind_o, rd_o, 4'd0, 5'd0);
      @(negedge clk) rst = 0;

      // R3 constant and PC-relative builds
      send("R3 lui+addi", enc_u(20'h12345, 5'd5, UPPER), enc_i(12'h678, 5'd5, 3'b000, 5'd5, IMM), 1, 1, ALL, 4'd5, 5'd5);
      send("R3 lui+addiw", enc_u(20'h00001, 5'd9, UPPER), enc_i(12'hFFF, 5'd9, 3'b000, 5'd9, IMM32), 1, 1, ALL, 4'd5, 5'd9);
      send("R3 auipc+addi", enc_u(20'h00010, 5'd7, AUIPC), enc_i(12'h010, 5'd7, 3'b000, 5'd7, IMM), 1, 1, ALL, 4'd6, 5'd7);
      send("R3 auipc+addiw none", enc_u(20'h00010, 5'd7, AUIPC), enc_i(12'h010, 5'd7, 3'b000, 5'd7, IMM32), 1, 1, ALL, 4'd0, 5'd0);
      // R4, R5, R6 shift pairs, R10 priority among them
      send("R4 zext half", enc_sh(6'd0, 6'd48, 5'd6, 3'b001, 5'd10), enc_sh(6'd0, 6'd48, 5'd10, 3'b101, 5'd10), 1, 1, ALL, 4'd1, 5'd10);
      send("R4 R10 zext word", enc_sh(6'd0, 6'd32, 5'd6, 3'b001, 5'd11), enc_sh(6'd0, 6'd32, 5'd11, 3'b101, 5'd11), 1, 1, ALL, 4'd2, 5'd11);
      send("R5 shifted 31", enc_sh(6'd0, 6'd32, 5'd6, 3'b001, 5'd12), enc_sh(6'd0, 6'd31, 5'd12, 3'b101, 5'd12), 1, 1, ALL, 4'd3, 5'd12);
      send("R5 shifted 0", enc_sh(6'd0, 6'd32, 5'd6, 3'b001, 5'd12), enc_sh(6'd0, 6'd0, 5'd12, 3'b101, 5'd12), 1, 1, ALL, 4'd3, 5'd12);
      send("R6 bitfield 32/33", enc_sh(6'd0, 6'd32, 5'd6, 3'b001, 5'd13), enc_sh(6'd0, 6'd33, 5'd13, 3'b101, 5'd13), 1, 1, ALL, 4'd4, 5'd13);
      send("R6 bitfield 10/20", enc_sh(6'd0, 6'd10, 5'd6, 3'b001, 5'd13), enc_sh(6'd0, 6'd20, 5'd13, 3'b101, 5'd13), 1, 1, ALL, 4'd4, 5'd13);
      send("R6 srai none", enc_sh(6'd0, 6'd32, 5'd6, 3'b001, 5'd13), enc_sh(6'b010000, 6'd32, 5'd13, 3'b101, 5'd13), 1, 1, ALL, 4'd0, 5'd0);
      // R7 add + load
      send("R7 add+ld0", enc_r(7'd0, 5'd8, 5'd6, 3'b000, 5'd14, REG), enc_i(12'd0, 5'd14, 3'b011, 5'd14, LOAD), 1, 1, ALL, 4'd7, 5'd14);
      send("R7 add+ld8", enc_r(7'd0, 5'd8, 5'd6, 3'b000, 5'd14, REG), enc_i(12'd8, 5'd14, 3'b011, 5'd14, LOAD), 1, 1, ALL, 4'd8, 5'd14);
      send("R7 add+lw0", enc_r(7'd0, 5'd8, 5'd6, 3'b000, 5'd14, REG), enc_i(12'd0, 5'd14, 3'b010, 5'd14, LOAD), 1, 1, ALL, 4'd8, 5'd14);
      send("R7 adduw+ld0", enc_r(7'b0000100, 5'd8, 5'd6, 3'b000, 5'd14, REG32), enc_i(12'd0, 5'd14, 3'b011, 5'd14, LOAD), 1, 1, ALL, 4'd8, 5'd14);
      // R8 other load pairs
      send("R8 sh2add+lbu", enc_r(7'b0010000, 5'd8, 5'd6, 3'b100, 5'd15, REG), enc_i(12'd4, 5'd15, 3'b100, 5'd15, LOAD), 1, 1, ALL, 4'd9, 5'd15);
      send("R8 sh3adduw+lhu", enc_r(7'b0010000, 5'd8, 5'd6, 3'b110, 5'd15, REG32), enc_i(12'd2, 5'd15, 3'b101, 5'd15, LOAD), 1, 1, ALL, 4'd9, 5'd15);
      send("R8 addi+lwu", enc_i(12'h100, 5'd6, 3'b000, 5'd16, IMM), enc_i(12'hFF8, 5'd16, 3'b110, 5'd16, LOAD), 1, 1, ALL, 4'd10, 5'd16);
      send("R8 auipc+lh", enc_u(20'h00002, 5'd17, AUIPC), enc_i(12'h020, 5'd17, 3'b001, 5'd17, LOAD), 1, 1, ALL, 4'd11, 5'd17);
      send("R8 lui+lb", enc_u(20'h80000, 5'd31, UPPER), enc_i(12'h7FF, 5'd31, 3'b000, 5'd31, LOAD), 1, 1, ALL, 4'd12, 5'd31);
      // R11 funct3 111 is not a load
      send("R11 f3=111 none", enc_r(7'd0, 5'd8, 5'd6, 3'b000, 5'd14, REG), enc_i(12'd0, 5'd14, 3'b111, 5'd14, LOAD), 1, 1, ALL, 4'd0, 5'd0);
      // R2 register dependence and valid bits
      send("R2 rd x0", enc_u(20'h12345, 5'd0, UPPER), enc_i(12'h678, 5'd0, 3'b000, 5'd0, IMM), 1, 1, ALL, 4'd0, 5'd0);
      send("R2 rs1 mismatch", enc_u(20'h12345, 5'd5, UPPER), enc_i(12'h678, 5'd6, 3'b000, 5'd5, IMM), 1, 1, ALL, 4'd0, 5'd0);
      send("R2 rd mismatch", enc_u(20'h12345, 5'd5, UPPER), enc_i(12'h678, 5'd5, 3'b000, 5'd6, IMM), 1, 1, ALL, 4'd0, 5'd0);
      send("R2 first invalid", enc_u(20'h12345, 5'd5, UPPER), enc_i(12'h678, 5'd5, 3'b000, 5'd5, IMM), 0, 1, ALL, 4'd0, 5'd0);
      send("R2 second invalid", enc_u(20'h12345, 5'd5, UPPER), enc_i(12'h678, 5'd5, 3'b000, 5'd5, IMM), 1, 0, ALL, 4'd0, 5'd0);
      // R9 enables
      send("R9 half off -> bitfield", enc_sh(6'd0, 6'd48, 5'd6, 3'b001, 5'd10), enc_sh(6'd0, 6'd48, 5'd10, 3'b101, 5'd10), 1, 1, 12'hFFE, 4'd4, 5'd10);
      send("R9 shifted off -> bitfield", enc_sh(6'd0, 6'd32, 5'd6, 3'b001, 5'd12), enc_sh(6'd0, 6'd5, 5'd12, 3'b101, 5'd12), 1, 1, 12'hFFB, 4'd4, 5'd12);
      send("R9 ld0 off -> addload", enc_r(7'd0, 5'd8, 5'd6, 3'b000, 5'd14, REG), enc_i(12'd0, 5'd14, 3'b011, 5'd14, LOAD), 1, 1, 12'hFBF, 4'd8, 5'd14);
      send("R9 upper-addi off", enc_u(20'h12345, 5'd5, UPPER), enc_i(12'h678, 5'd5, 3'b000, 5'd5, IMM), 1, 1, 12'hFEF, 4'd0, 5'd0);
      send("R9 all off", enc_sh(6'd0, 6'd48, 5'd6, 3'b001, 5'd10), enc_sh(6'd0, 6'd48, 5'd10, 3'b101, 5'd10), 1, 1, 12'h000, 4'd0, 5'd0);
      send("R9 only lui-load", enc_u(20'h80000, 5'd3, UPPER), enc_i(12'h004, 5'd3, 3'b011, 5'd3, LOAD), 1, 1, 12'h800, 4'd12, 5'd3);
      // R1 back-to-back: result follows each pair exactly one edge later
      send("R1 b2b first", enc_u(20'h00010, 5'd7, AUIPC), enc_i(12'h010, 5'd7, 3'b000, 5'd7, IMM), 1, 1, ALL, 4'd6, 5'd7);
      send("R1 b2b second", enc_r(7'd0, 5'd8, 5'd6, 3'b000, 5'd20, REG), enc_i(12'd0, 5'd20, 3'b011, 5'd20, LOAD), 1, 1, ALL, 4'd7, 5'd20);
      send("R1 b2b idle", 32'd0, 32'd0, 0, 0, ALL, 4'd0, 5'd0);

      repeat (4) @(posedge clk);
      #3;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule